// File: doc/BRIEF.md
# Hardware Process Run-Queue Scheduler

This block decides which lightweight process owns a single shared execution unit. Each process is named by the index of its workspace, a small record held inside the block. A workspace holds two words: a link word that chains ready processes together, and a saved instruction pointer. The ready processes form a singly linked list threaded through these link words. A head register marks the oldest ready process and a tail register marks the newest. No separate queue storage exists. Index 0 is reserved as the null value, so it names no process.

A process is either running, queued as ready, or blocked. A process blocks when it waits to receive, waits to send, or waits on a timer. Blocked processes are on no list, so the block spends no cycles on them. When the running process blocks, its environment pulses the deschedule port with the process's current instruction pointer. The block stores that pointer into the process's own workspace and hands the unit to the process at the head of the list. No other context is saved. When a blocked process becomes ready again, the enqueue port appends it at the tail. The enqueue port can also load a fresh start address into the workspace, for a process that has never run. Whenever nothing is running and the list holds a process, the head process is dispatched automatically.

Top module: `rq_sched`

## Requirements
- R1: After synchronous reset, `idle` is 1, `run_valid` is 0, and the ready list is empty.
- R2: If an enqueue with a non-null id arrives while the block is idle, that process is dispatched two clock edges later. The first edge links it into the list and the second makes it run. `run_id` then shows the id, and `run_ip` shows the instruction pointer held in its workspace.
- R3: Ready processes are dispatched strictly in the order they were enqueued. Dispatch always removes the head of the list, and appending always adds after the tail.
- R4: A deschedule writes `desched_ip` into the running process's workspace. When that process is later enqueued with `enq_load_ip` = 0 and dispatched, `run_ip` shows the stored value.
- R5: A running process keeps the unit until it is descheduled, however many other processes are enqueued meanwhile (no preemption).
- R6: If the running process is descheduled while the ready list is empty, `run_valid` drops to 0 and `idle` rises to 1 after that edge.
- R7: If a deschedule and an enqueue land on the same edge, the head is removed first and the new process is appended afterwards. Two cases follow. With a one-entry list, the old head runs and the new process becomes the only entry. With an empty list, nothing runs for one cycle and the new process runs on the next edge.
- R8: `idle` is 1 exactly when no process is running and the ready list is empty. It is 0 while a process runs.
- R9: An enqueue whose id is the null value 0 changes nothing: the block stays idle and nothing is dispatched.
- R10: A deschedule while nothing is running is ignored. No workspace is written and the output state is unchanged.
- R11: An enqueue with `enq_load_ip` = 1 overwrites the process's saved instruction pointer with `enq_ip`, and that value is shown in `run_ip` when the process is dispatched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Make the process `enq_id` ready this cycle |
| enq_id | input | IDW (4) | Workspace index of the process to enqueue; 0 is null |
| enq_load_ip | input | 1 | 1: write `enq_ip` into the workspace as the start address |
| enq_ip | input | IPW (16) | Start address used when `enq_load_ip` is 1 |
| desched_valid | input | 1 | The running process blocks this cycle |
| desched_ip | input | IPW (16) | Instruction pointer of the blocking process |
| run_valid | output | 1 | A process currently owns the unit |
| run_id | output | IDW (4) | Workspace index of the running process |
| run_ip | output | IPW (16) | Saved instruction pointer of the running process (0 when none) |
| idle | output | 1 | Nothing running and ready list empty |

## Verification
The main walk builds lists of one, two and three entries and deschedules through them, so that dispatch order can be checked against arrival order. It re-enqueues processes without loading an address, which shows whether saved instruction pointers come back intact or are overwritten by a later write. Simultaneous deschedule and enqueue is tried against a one-entry list and against an empty list, including a process that re-enqueues itself; the two orderings (dequeue first or append first) predict different dispatch results. Null-id enqueues, deschedules with no running process, and a mid-run reset probe the cases the block must leave alone.

// File: rtl/rq_pkg.sv
package rq_pkg;

    // Workspace index 0 never names a process; it marks an empty list or link.
    localparam int unsigned NULL_ID = 0;

    // What the list controller is asked to do on one edge.
    typedef struct packed {
        logic deq;   // remove the head (dispatch)
        logic app;   // append a new process at the tail
    } qop_t;

    // Occupancy of the execution unit.
    typedef enum logic {
        CORE_EMPTY = 1'b0,
        CORE_BUSY  = 1'b1
    } core_state_e;

    // True when the list would be non-empty after an optional head removal.
    function automatic logic keeps_entries(input logic deq, input logic head_null,
                                           input logic next_null);
        return deq ? !next_null : !head_null;
    endfunction

endpackage

// File: rtl/rq_ws_store.sv
// Per-process workspace storage: a link word and a saved instruction pointer
// for every slot. SLOTS is expected to be a power of two.
module rq_ws_store #(
    parameter int SLOTS = 16,
    parameter int IDW   = 4,
    parameter int IPW   = 16
) (
    input  logic           clk,
    input  logic           rst,
    // link write port A: tail -> new entry
    input  logic           lnk_a_we,
    input  logic [IDW-1:0] lnk_a_addr,
    input  logic [IDW-1:0] lnk_a_data,
    // link write port B: terminate new entry (wins on collision)
    input  logic           lnk_b_we,
    input  logic [IDW-1:0] lnk_b_addr,
    input  logic [IDW-1:0] lnk_b_data,
    // IP write port A: deschedule save
    input  logic           ip_a_we,
    input  logic [IDW-1:0] ip_a_addr,
    input  logic [IPW-1:0] ip_a_data,
    // IP write port B: start-address load (wins on collision)
    input  logic           ip_b_we,
    input  logic [IDW-1:0] ip_b_addr,
    input  logic [IPW-1:0] ip_b_data,
    // read ports
    input  logic [IDW-1:0] lnk_raddr,
    output logic [IDW-1:0] lnk_rdata,
    input  logic [IDW-1:0] ip_raddr,
    output logic [IPW-1:0] ip_rdata
);

    logic [SLOTS-1:0][IDW-1:0] lnk_vec;
    logic [SLOTS-1:0][IPW-1:0] ip_vec;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [IDW-1:0] lnk_r;
        logic [IPW-1:0] ip_r;
        logic           hit_la, hit_lb, hit_ia, hit_ib;

        always_comb begin
            hit_la = lnk_a_we && (lnk_a_addr == IDW'(s));
            hit_lb = lnk_b_we && (lnk_b_addr == IDW'(s));
            hit_ia = ip_a_we  && (ip_a_addr  == IDW'(s));
            hit_ib = ip_b_we  && (ip_b_addr  == IDW'(s));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lnk_r <= '0;
                ip_r  <= '0;
            end else begin
                if (hit_lb)      lnk_r <= lnk_b_data;
                else if (hit_la) lnk_r <= lnk_a_data;
                if (hit_ib)      ip_r  <= ip_b_data;
                else if (hit_ia) ip_r  <= ip_a_data;
            end
        end

        assign lnk_vec[s] = lnk_r;
        assign ip_vec[s]  = ip_r;
    end

    assign lnk_rdata = lnk_vec[lnk_raddr];
    assign ip_rdata  = ip_vec[ip_raddr];

endmodule

// File: rtl/rq_list_ctrl.sv
// Head/tail registers of the ready list. A head removal is resolved before an
// append in the same cycle.
module rq_list_ctrl
    import rq_pkg::*;
#(
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  qop_t           op,
    input  logic [IDW-1:0] app_id,
    input  logic [IDW-1:0] head_link,   // link word of the current head
    output logic [IDW-1:0] head,
    output logic [IDW-1:0] tail,
    output logic           empty,
    output logic           lnk_tail_we,
    output logic [IDW-1:0] lnk_tail_addr,
    output logic [IDW-1:0] lnk_tail_data,
    output logic           lnk_new_we,
    output logic [IDW-1:0] lnk_new_addr,
    output logic [IDW-1:0] lnk_new_data
);

    localparam logic [IDW-1:0] NIL = IDW'(NULL_ID);

    logic [IDW-1:0] head_q, tail_q;
    logic [IDW-1:0] mid_head, mid_tail;   // list state after removal, before append
    logic [IDW-1:0] head_d, tail_d;
    logic           mid_live;

    always_comb begin
        mid_live = keeps_entries(op.deq, head_q == NIL, head_link == NIL);
        mid_head = op.deq ? head_link : head_q;
        mid_tail = mid_live ? tail_q : NIL;

        head_d = mid_live ? mid_head : NIL;
        tail_d = mid_tail;
        lnk_tail_we   = 1'b0;
        lnk_tail_addr = mid_tail;
        lnk_tail_data = app_id;
        lnk_new_we    = op.app;
        lnk_new_addr  = app_id;
        lnk_new_data  = NIL;

        if (op.app) begin
            if (mid_live) lnk_tail_we = 1'b1;
            else          head_d      = app_id;
            tail_d = app_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= NIL;
            tail_q <= NIL;
        end else begin
            head_q <= head_d;
            tail_q <= tail_d;
        end
    end

    assign head  = head_q;
    assign tail  = tail_q;
    assign empty = (head_q == NIL);

    // R3
    list_ends_consistent_chk: assert property (@(posedge clk) disable iff (rst)
        (head_q == NIL) == (tail_q == NIL));

    // R3
    head_follows_link_chk: assert property (@(posedge clk) disable iff (rst)
        (op.deq && !op.app) |=> (head_q == $past(head_link)));

    // R3
    append_becomes_tail_chk: assert property (@(posedge clk) disable iff (rst)
        op.app |=> (tail_q == $past(app_id)));

endmodule

// File: rtl/rq_core_slot.sv
// Holds the identity of the process that owns the execution unit and asks the
// list for the next one whenever the unit is free or being released.
module rq_core_slot
    import rq_pkg::*;
#(
    parameter int IDW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           desched_valid,
    input  logic [IDW-1:0] head,
    input  logic           empty,
    output logic           deq,
    output logic           busy,
    output logic           release_now,
    output logic [IDW-1:0] cur_id
);

    core_state_e    state_q, state_d;
    logic [IDW-1:0] cur_q, cur_d;

    always_comb begin
        release_now = (state_q == CORE_BUSY) && desched_valid;
        deq         = ((state_q == CORE_EMPTY) || release_now) && !empty;
        state_d     = state_q;
        cur_d       = cur_q;
        if (deq) begin
            state_d = CORE_BUSY;
            cur_d   = head;
        end else if (release_now) begin
            state_d = CORE_EMPTY;
            cur_d   = IDW'(NULL_ID);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CORE_EMPTY;
            cur_q   <= IDW'(NULL_ID);
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    assign busy   = (state_q == CORE_BUSY);
    assign cur_id = cur_q;

    // R5
    no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !desched_valid) |=> (busy && $stable(cur_q)));

    // R6
    release_to_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && desched_valid && empty) |=> !busy);

    // R3
    dispatch_takes_head_chk: assert property (@(posedge clk) disable iff (rst)
        deq |=> (busy && cur_q == $past(head)));

endmodule

// File: rtl/rq_sched.sv
module rq_sched
    import rq_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int IPW   = 16,
    localparam int IDW  = $clog2(SLOTS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           enq_valid,
    input  logic [IDW-1:0] enq_id,
    input  logic           enq_load_ip,
    input  logic [IPW-1:0] enq_ip,
    input  logic           desched_valid,
    input  logic [IPW-1:0] desched_ip,
    output logic           run_valid,
    output logic [IDW-1:0] run_id,
    output logic [IPW-1:0] run_ip,
    output logic           idle
);

    qop_t           op;
    logic           deq, busy, release_now, empty;
    logic [IDW-1:0] cur_id, head, tail, head_link;
    logic [IPW-1:0] ip_rd;
    logic           lnk_tail_we, lnk_new_we;
    logic [IDW-1:0] lnk_tail_addr, lnk_tail_data, lnk_new_addr, lnk_new_data;
    logic           app_ok;

    assign app_ok = enq_valid && (enq_id != IDW'(NULL_ID));

    always_comb begin
        op.deq = deq;
        op.app = app_ok;
    end

    rq_core_slot #(.IDW(IDW)) u_core (
        .clk           (clk),
        .rst           (rst),
        .desched_valid (desched_valid),
        .head          (head),
        .empty         (empty),
        .deq           (deq),
        .busy          (busy),
        .release_now   (release_now),
        .cur_id        (cur_id)
    );

    rq_list_ctrl #(.IDW(IDW)) u_list (
        .clk           (clk),
        .rst           (rst),
        .op            (op),
        .app_id        (enq_id),
        .head_link     (head_link),
        .head          (head),
        .tail          (tail),
        .empty         (empty),
        .lnk_tail_we   (lnk_tail_we),
        .lnk_tail_addr (lnk_tail_addr),
        .lnk_tail_data (lnk_tail_data),
        .lnk_new_we    (lnk_new_we),
        .lnk_new_addr  (lnk_new_addr),
        .lnk_new_data  (lnk_new_data)
    );

    rq_ws_store #(.SLOTS(SLOTS), .IDW(IDW), .IPW(IPW)) u_ws (
        .clk        (clk),
        .rst        (rst),
        .lnk_a_we   (lnk_tail_we),
        .lnk_a_addr (lnk_tail_addr),
        .lnk_a_data (lnk_tail_data),
        .lnk_b_we   (lnk_new_we),
        .lnk_b_addr (lnk_new_addr),
        .lnk_b_data (lnk_new_data),
        .ip_a_we    (release_now),
        .ip_a_addr  (cur_id),
        .ip_a_data  (desched_ip),
        .ip_b_we    (app_ok && enq_load_ip),
        .ip_b_addr  (enq_id),
        .ip_b_data  (enq_ip),
        .lnk_raddr  (head),
        .lnk_rdata  (head_link),
        .ip_raddr   (cur_id),
        .ip_rdata   (ip_rd)
    );

    assign run_valid = busy;
    assign run_id    = cur_id;
    assign run_ip    = busy ? ip_rd : '0;
    assign idle      = !busy && empty;

    // R2
    idle_wakes_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && enq_valid && enq_id != '0) |=> !idle);

    // R8, R9
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !(enq_valid && enq_id != '0)) |=> idle);

    // R8
    running_not_idle_chk: assert property (@(posedge clk) disable iff (rst)
        run_valid |-> !idle);

    // R10
    stray_desched_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_valid && desched_valid && !enq_valid && tail == '0) |=> !run_valid);

endmodule

// File: tb/sim_rq_sched.sv
`timescale 1ns/1ps
module sim_rq_sched;

    localparam int SLOTS = 16;
    localparam int IPW   = 16;
    localparam int IDW   = $clog2(SLOTS);
    localparam int NROW  = 19;

    logic           clk = 1'b0;
    logic           rst;
    logic           enq_valid, enq_load_ip, desched_valid;
    logic [IDW-1:0] enq_id;
    logic [IPW-1:0] enq_ip, desched_ip;
    logic           run_valid, idle;
    logic [IDW-1:0] run_id;
    logic [IPW-1:0] run_ip;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    rq_sched #(.SLOTS(SLOTS), .IPW(IPW)) u0 (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_id(enq_id), .enq_load_ip(enq_load_ip), .enq_ip(enq_ip),
        .desched_valid(desched_valid), .desched_ip(desched_ip),
        .run_valid(run_valid), .run_id(run_id), .run_ip(run_ip), .idle(idle)
    );

    typedef struct packed {
        logic           ev;
        logic [IDW-1:0] eid;
        logic           eld;
        logic [IPW-1:0] eip;
        logic           ds;
        logic [IPW-1:0] dip;
        logic           xrv;
        logic [IDW-1:0] xid;
        logic [IPW-1:0] xip;
        logic           xidle;
    } vec_t;

    // Each row is applied for one edge; expected outputs are those after it.
    localparam vec_t TAB [NROW] = '{
        '{1'b1, 4'd1, 1'b1, 16'h0100, 1'b0, 16'h0000, 1'b0, 4'd0, 16'h0000, 1'b0}, // R2 linked
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 4'd1, 16'h0100, 1'b0}, // R2 dispatched
        '{1'b1, 4'd2, 1'b1, 16'h0200, 1'b0, 16'h0000, 1'b1, 4'd1, 16'h0100, 1'b0}, // R5
        '{1'b1, 4'd3, 1'b1, 16'h0300, 1'b0, 16'h0000, 1'b1, 4'd1, 16'h0100, 1'b0}, // R5
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b1, 16'h0111, 1'b1, 4'd2, 16'h0200, 1'b0}, // R3
        '{1'b1, 4'd1, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 4'd2, 16'h0200, 1'b0}, // R5
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b1, 16'h0222, 1'b1, 4'd3, 16'h0300, 1'b0}, // R3
        '{1'b1, 4'd2, 1'b0, 16'h0000, 1'b1, 16'h0333, 1'b1, 4'd1, 16'h0111, 1'b0}, // R7 R4
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b1, 16'h0144, 1'b1, 4'd2, 16'h0222, 1'b0}, // R7 R4
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b1, 16'h0255, 1'b0, 4'd0, 16'h0000, 1'b1}, // R6
        '{1'b1, 4'd0, 1'b1, 16'h0ABC, 1'b0, 16'h0000, 1'b0, 4'd0, 16'h0000, 1'b1}, // R9
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b1, 16'h0999, 1'b0, 4'd0, 16'h0000, 1'b1}, // R10
        '{1'b1, 4'd2, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'd0, 16'h0000, 1'b0}, // R2
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 4'd2, 16'h0255, 1'b0}, // R4 R10
        '{1'b1, 4'd2, 1'b0, 16'h0000, 1'b1, 16'h0260, 1'b0, 4'd0, 16'h0000, 1'b0}, // R7 empty
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 4'd2, 16'h0260, 1'b0}, // R7 R4
        '{1'b1, 4'd3, 1'b1, 16'h03A0, 1'b0, 16'h0000, 1'b1, 4'd2, 16'h0260, 1'b0}, // R11
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b1, 16'h0270, 1'b1, 4'd3, 16'h03A0, 1'b0}, // R11
        '{1'b0, 4'd0, 1'b0, 16'h0000, 1'b1, 16'h03B0, 1'b0, 4'd0, 16'h0000, 1'b1}  // R6 R8
    };

    localparam string TAGS [NROW] = '{
        "R2", "R2", "R5", "R5", "R3", "R5", "R3", "R7", "R7", "R6",
        "R9", "R10", "R2", "R4", "R7", "R7", "R11", "R11", "R8"
    };

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        enq_valid = 1'b0; enq_id = '0; enq_load_ip = 1'b0; enq_ip = '0;
        desched_valid = 1'b0; desched_ip = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        step();
        rst = 1'b0;

        // R1: reset state
        chk("R1", "idle", 32'(idle), 32'd1);
        chk("R1", "run_valid", 32'(run_valid), 32'd0);

        for (int i = 0; i < NROW; i++) begin
            enq_valid     = TAB[i].ev;
            enq_id        = TAB[i].eid;
            enq_load_ip   = TAB[i].eld;
            enq_ip        = TAB[i].eip;
            desched_valid = TAB[i].ds;
            desched_ip    = TAB[i].dip;
            step();
            idle_inputs();
            chk(TAGS[i], $sformatf("row%0d run_valid", i), 32'(run_valid), 32'(TAB[i].xrv));
            chk(TAGS[i], $sformatf("row%0d idle", i), 32'(idle), 32'(TAB[i].xidle));
            if (TAB[i].xrv) begin
                chk(TAGS[i], $sformatf("row%0d run_id", i), 32'(run_id), 32'(TAB[i].xid));
                chk(TAGS[i], $sformatf("row%0d run_ip", i), 32'(run_ip), 32'(TAB[i].xip));
            end
        end

        // R9: null enqueue followed by quiet cycles never dispatches
        enq_valid = 1'b1; enq_id = '0; enq_load_ip = 1'b1; enq_ip = 16'h1234;
        step();
        idle_inputs();
        step();
        chk("R9", "run_valid after null enq", 32'(run_valid), 32'd0);
        chk("R9", "idle after null enq", 32'(idle), 32'd1);

        // R1: reset in the middle of activity empties the list
        enq_valid = 1'b1; enq_id = 4'd5; enq_load_ip = 1'b1; enq_ip = 16'h0500;
        step();
        enq_id = 4'd6; enq_ip = 16'h0600;
        step();
        idle_inputs();
        chk("R2", "run_id before reset", 32'(run_id), 32'd5);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R1", "idle after reset", 32'(idle), 32'd1);
        step();
        chk("R1", "no dispatch after reset", 32'(run_valid), 32'd0);

        done = 1;
        summary();
        $finish;
    end

endmodule